// File: doc/BRIEF.md
# Debug Trace Data Serializer

This block sits beside a processor core. It turns selected execution events into a stream of nibbles on a narrow trace port that an external debugger samples. There are two event sources. The first is operand accesses, which carry a direction (read or write), a size tag and up to 32 bits of data. The second is taken changes of flow, which carry a 32-bit destination address and a flag that says whether the destination was computed by a variant addressing mode. Instruction decoding and the debugger itself lie outside the block.

Two configuration fields control capture. An operand field chooses whether reads, writes, both or neither are captured. A target field chooses how many low-order bytes of a destination address are emitted. Each accepted event becomes one queued item. The configuration that applies to it is frozen when the item is queued. A shifter drains the queue one nibble per cycle, starting with the least significant byte and the low nibble of each byte. A sticky flag reports that an event was lost because the queue had no free entry.

Top module: `trc_serializer`

## Requirements
- R1: The 2-bit `cfg_opnd` field filters operand events by direction: 00 captures nothing, 01 captures only writes (`op_write`=1), 10 captures only reads, 11 captures both. A filtered-out operand produces no nibbles.
- R2: A captured operand emits as many bytes as its `op_size` tag: 00 gives 1 byte, 01 gives 2 bytes, 10 and 11 give 4 bytes. Data bits above that size are never emitted.
- R3: A captured destination emits a byte count set by the 2-bit `cfg_tgt` field: 00 gives none, 01 gives the low 2 bytes, 10 gives the low 3 bytes, 11 gives all 4 bytes.
- R4: A change-of-flow event is captured only when `br_valid` and `br_variant` are both 1. With `br_variant`=0 nothing is emitted.
- R5: Bytes go out from least to most significant. Each byte is sent as two 4-bit nibbles on `trc_nib`, low nibble first. `trc_vld` is 1 in exactly the cycles that carry a nibble.
- R6: When an operand and a destination are both captured in one cycle, the operand item is queued, and therefore emitted, before the destination item.
- R7: Up to DEPTH (default 8) items wait in the queue. An event that finds no free entry is dropped and `trc_ovf` goes to 1. If only one entry is free for two events, the operand takes it. `trc_ovf` stays 1 until reset. Free space is judged on the occupancy before the cycle's removal.
- R8: `cfg_opnd` and `cfg_tgt` are sampled in the cycle an event is accepted. Changes made later do not alter an item that is already queued.
- R9: While `rst_n` is 0 and after reset, `trc_vld` and `trc_ovf` are 0 and the queue is empty.
- R10: Queued items stream back to back: the first nibble of the next item follows the last nibble of the previous one with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_opnd | input | 2 | Operand capture selection |
| cfg_tgt | input | 2 | Destination byte count selection |
| op_valid | input | 1 | Operand access present this cycle |
| op_write | input | 1 | 1 for a write access, 0 for a read |
| op_size | input | 2 | Access size tag |
| op_data | input | 32 | Operand data, byte 0 in bits 7:0 |
| br_valid | input | 1 | Taken change of flow present this cycle |
| br_variant | input | 1 | Destination came from variant addressing |
| br_target | input | 32 | Destination address |
| trc_nib | output | 4 | Trace nibble |
| trc_vld | output | 1 | Trace nibble valid |
| trc_ovf | output | 1 | Sticky event-lost flag |

## Verification
The hardest state to reach is a full queue at the exact moment an operand and a destination arrive together with only one free entry. Random stimulus spaces its events so that the queue never fills, and it changes the configuration every cycle while items wait. A directed burst then presents a captured long operand and a 4-byte destination in five consecutive cycles, followed by a lone operand. The shifter removes only one item during that window, so the fifth cycle meets exactly one free entry and the sixth meets none. The bench predicts which items survive, checks the overflow flag, and checks that the 72 surviving nibbles arrive without a gap.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int unsigned WORD_W        = 32;
    localparam int unsigned WORD_BYTES    = WORD_W / 8;
    localparam int unsigned NIB_W         = 4;
    localparam int unsigned NIBS_PER_BYTE = 8 / NIB_W;
    localparam int unsigned LEN_W         = $clog2(WORD_BYTES + 1);
    localparam int unsigned NCNT_W        = $clog2(WORD_BYTES * NIBS_PER_BYTE + 1);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } op_size_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LEN_W-1:0]  nbytes;
    } trc_item_t;
endpackage

// File: rtl/trc_capture.sv
module trc_capture
    import trc_pkg::*;
(
    input  logic [1:0]        cfg_opnd,
    input  logic [1:0]        cfg_tgt,
    input  logic              op_valid,
    input  logic              op_write,
    input  logic [1:0]        op_size,
    input  logic [WORD_W-1:0] op_data,
    input  logic              br_valid,
    input  logic              br_variant,
    input  logic [WORD_W-1:0] br_target,
    output logic              op_take,
    output trc_item_t         op_item,
    output logic              br_take,
    output trc_item_t         br_item
);
    logic [LEN_W-1:0]  op_len;
    logic [LEN_W-1:0]  br_len;
    logic [WORD_W-1:0] op_mask;
    logic [WORD_W-1:0] br_mask;

    always_comb begin
        case (op_size_e'(op_size))
            SZ_BYTE: op_len = LEN_W'(1);
            SZ_WORD: op_len = LEN_W'(2);
            default: op_len = LEN_W'(WORD_BYTES);
        endcase
        case (cfg_tgt)
            2'b01:   br_len = LEN_W'(2);
            2'b10:   br_len = LEN_W'(3);
            2'b11:   br_len = LEN_W'(4);
            default: br_len = '0;
        endcase
    end

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_mask
        assign op_mask[b*8 +: 8] = (op_len > LEN_W'(b)) ? 8'hFF : 8'h00;
        assign br_mask[b*8 +: 8] = (br_len > LEN_W'(b)) ? 8'hFF : 8'h00;
    end

    always_comb begin
        op_take        = op_valid && (op_write ? cfg_opnd[0] : cfg_opnd[1]);
        op_item.data   = op_data & op_mask;
        op_item.nbytes = op_len;
        br_take        = br_valid && br_variant && (br_len != '0);
        br_item.data   = br_target & br_mask;
        br_item.nbytes = br_len;
    end
endmodule

// File: rtl/trc_queue.sv
module trc_queue
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  trc_item_t        item_a,
    input  logic             push_b,
    input  trc_item_t        item_b,
    input  logic             pop,
    output trc_item_t        head,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } q_state_t;

    q_state_t  st_d, st_q;
    trc_item_t mem_d [DEPTH];
    trc_item_t mem_q [DEPTH];

    logic [CNT_W-1:0] space;
    logic             acc_a;
    logic             acc_b;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        space = CNT_W'(DEPTH) - st_q.cnt;
        acc_a = push_a && (space != '0);
        acc_b = push_b && (space >= (acc_a ? CNT_W'(2) : CNT_W'(1)));

        if (acc_a) begin
            mem_d[st_q.wr] = item_a;
        end
        if (acc_b) begin
            mem_d[acc_a ? step(st_q.wr) : st_q.wr] = item_b;
        end
        if (acc_a && acc_b) begin
            st_d.wr = step(step(st_q.wr));
        end else if (acc_a || acc_b) begin
            st_d.wr = step(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop);
        if ((push_a && !acc_a) || (push_b && !acc_b)) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign head  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/trc_shifter.sv
module trc_shifter
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  trc_item_t         head,
    input  logic              empty,
    output logic              pop,
    output logic [NIB_W-1:0]  nib,
    output logic              vld,
    output logic [NCNT_W-1:0] left
);
    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] sh;
        logic [NCNT_W-1:0] left;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = !empty && (!st_q.busy || st_q.left == NCNT_W'(1));
        if (st_q.busy) begin
            st_d.sh   = st_q.sh >> NIB_W;
            st_d.left = st_q.left - NCNT_W'(1);
            if (st_q.left == NCNT_W'(1)) begin
                st_d.busy = 1'b0;
            end
        end
        if (pop) begin
            st_d.busy = 1'b1;
            st_d.sh   = head.data;
            st_d.left = NCNT_W'(head.nbytes * NIBS_PER_BYTE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nib  = st_q.sh[NIB_W-1:0];
    assign vld  = st_q.busy;
    assign left = st_q.left;
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_opnd,
    input  logic [1:0]  cfg_tgt,
    input  logic        op_valid,
    input  logic        op_write,
    input  logic [1:0]  op_size,
    input  logic [31:0] op_data,
    input  logic        br_valid,
    input  logic        br_variant,
    input  logic [31:0] br_target,
    output logic [3:0]  trc_nib,
    output logic        trc_vld,
    output logic        trc_ovf
);
    logic              op_take;
    logic              br_take;
    trc_item_t         op_item;
    trc_item_t         br_item;
    trc_item_t         q_head;
    logic              q_empty;
    logic              q_pop;
    logic [CNT_W-1:0]  q_count;
    logic [NCNT_W-1:0] sh_left;

    trc_capture u_capture (
        .cfg_opnd   (cfg_opnd),
        .cfg_tgt    (cfg_tgt),
        .op_valid   (op_valid),
        .op_write   (op_write),
        .op_size    (op_size),
        .op_data    (op_data),
        .br_valid   (br_valid),
        .br_variant (br_variant),
        .br_target  (br_target),
        .op_take    (op_take),
        .op_item    (op_item),
        .br_take    (br_take),
        .br_item    (br_item)
    );

    trc_queue #(.DEPTH(DEPTH)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (op_take),
        .item_a (op_item),
        .push_b (br_take),
        .item_b (br_item),
        .pop    (q_pop),
        .head   (q_head),
        .empty  (q_empty),
        .count  (q_count),
        .ovf    (trc_ovf)
    );

    trc_shifter u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .head  (q_head),
        .empty (q_empty),
        .pop   (q_pop),
        .nib   (trc_nib),
        .vld   (trc_vld),
        .left  (sh_left)
    );
endmodule

// File: rtl/trc_serializer_chk.sv
module trc_serializer_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned NCNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trc_vld,
    input logic              trc_ovf,
    input logic              q_pop,
    input logic              q_empty,
    input logic [CNT_W-1:0]  q_count,
    input logic [NCNT_W-1:0] sh_left,
    input logic              op_take,
    input logic              br_take
);
    // R7
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= int'(DEPTH));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trc_ovf |=> trc_ovf);

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trc_ovf) |-> (int'($past(q_count)) + int'($past(op_take))
                            + int'($past(br_take)) > int'(DEPTH)));

    // R6
    dual_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_take && br_take && (int'(q_count) + 2 <= int'(DEPTH)))
        |=> (int'(q_count) == int'($past(q_count)) + 2 - int'($past(q_pop))));

    // R10
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_vld && sh_left == NCNT_W'(1) && !q_empty) |=> trc_vld);

    // R5
    pop_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !q_empty);
endmodule

bind trc_serializer trc_serializer_chk #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .NCNT_W (trc_pkg::NCNT_W)
) chk (.*);

// File: tb/trc_serializer_test.sv
`timescale 1ns/1ps
module trc_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_opnd, cfg_tgt;
    logic        op_valid, op_write;
    logic [1:0]  op_size;
    logic [31:0] op_data;
    logic        br_valid, br_variant;
    logic [31:0] br_target;
    logic [3:0]  trc_nib;
    logic        trc_vld, trc_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;
    int first_v = -1;
    int last_v = -1;
    logic [3:0] exp_nib[$];
    string      exp_tag[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    trc_serializer uut (
        .clk(clk), .rst_n(rst_n), .cfg_opnd(cfg_opnd), .cfg_tgt(cfg_tgt),
        .op_valid(op_valid), .op_write(op_write), .op_size(op_size),
        .op_data(op_data), .br_valid(br_valid), .br_variant(br_variant),
        .br_target(br_target), .trc_nib(trc_nib), .trc_vld(trc_vld),
        .trc_ovf(trc_ovf)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int op_len(input logic [1:0] sz);
        case (sz)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int tgt_len(input logic [1:0] c);
        case (c)
            2'b01:   return 2;
            2'b10:   return 3;
            2'b11:   return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit op_en(input logic [1:0] c, input bit w);
        return w ? c[0] : c[1];
    endfunction

    task automatic expect_item(input logic [31:0] d, input int n, input string tag);
        for (int b = 0; b < n; b++) begin
            for (int h = 0; h < 2; h++) begin
                exp_nib.push_back(4'((d >> (8 * b + 4 * h)) & 32'hF));
                exp_tag.push_back(tag);
            end
        end
    endtask

    always @(negedge clk) begin
        logic [3:0] e;
        string      t;
        if (rst_n === 1'b1 && trc_vld) begin
            if (first_v < 0) first_v = cyc;
            last_v = cyc;
            if (exp_nib.size() == 0) begin
                check(1'b0, "R5", "unexpected nibble", trc_nib, 0);
            end else begin
                e = exp_nib.pop_front();
                t = exp_tag.pop_front();
                check(trc_nib == e, t, "nibble", trc_nib, e);
            end
        end
    end

    // Called at a falling edge; presents one event cycle and returns at the next falling edge.
    task automatic ev(input bit ov, input bit ow, input logic [1:0] sz,
                      input logic [31:0] od, input bit bv, input bit bvar,
                      input logic [31:0] bt, input bit keep_op, input bit keep_br,
                      input string tag);
        op_valid = ov; op_write = ow; op_size = sz; op_data = od;
        br_valid = bv; br_variant = bvar; br_target = bt;
        if (ov && op_en(cfg_opnd, ow) && keep_op) expect_item(od, op_len(sz), tag);
        if (bv && bvar && tgt_len(cfg_tgt) > 0 && keep_br)
            expect_item(bt, tgt_len(cfg_tgt), tag);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        br_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_nib.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
        check(exp_nib.size() == 0, tag, "pending nibbles", exp_nib.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_7A11));
        rst_n = 1'b0; cfg_opnd = 2'b00; cfg_tgt = 2'b00;
        op_valid = 1'b0; op_write = 1'b0; op_size = 2'b00; op_data = '0;
        br_valid = 1'b0; br_variant = 1'b0; br_target = '0;
        repeat (4) @(negedge clk);
        check(trc_vld == 1'b0, "R9", "vld in reset", trc_vld, 0);
        check(trc_ovf == 1'b0, "R9", "ovf in reset", trc_ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(trc_vld == 1'b0 && trc_ovf == 1'b0, "R9", "idle after reset",
              {trc_vld, trc_ovf}, 0);

        // R1: direction filter
        cfg_opnd = 2'b01;
        ev(1, 1, 2'b00, 32'h0000_00A5, 0, 0, 0, 1, 1, "R1");
        ev(1, 0, 2'b00, 32'h0000_005A, 0, 0, 0, 1, 1, "R1");
        cfg_opnd = 2'b10;
        ev(1, 0, 2'b01, 32'h0000_1234, 0, 0, 0, 1, 1, "R1");
        ev(1, 1, 2'b01, 32'h0000_4321, 0, 0, 0, 1, 1, "R1");
        cfg_opnd = 2'b00;
        ev(1, 1, 2'b10, 32'h1111_1111, 0, 0, 0, 1, 1, "R1");
        ev(1, 0, 2'b10, 32'h2222_2222, 0, 0, 0, 1, 1, "R1");
        cfg_opnd = 2'b11;
        ev(1, 1, 2'b00, 32'h0000_0096, 0, 0, 0, 1, 1, "R1");
        ev(1, 0, 2'b00, 32'h0000_0069, 0, 0, 0, 1, 1, "R1");
        drain("R1");

        // R2: size decides byte count, upper bits never emitted
        ev(1, 1, 2'b00, 32'hFFFF_FF3C, 0, 0, 0, 1, 1, "R2");
        ev(1, 0, 2'b01, 32'hEEEE_B7C4, 0, 0, 0, 1, 1, "R2");
        ev(1, 1, 2'b10, 32'h8765_4321, 0, 0, 0, 1, 1, "R2");
        ev(1, 0, 2'b11, 32'h0F1E_2D3C, 0, 0, 0, 1, 1, "R2");
        drain("R2");

        // R4: non-variant changes of flow ignored
        cfg_tgt = 2'b11;
        ev(0, 0, 0, 0, 1, 0, 32'hABCD_EF01, 1, 1, "R4");
        drain("R4");
        ev(0, 0, 0, 0, 1, 1, 32'hABCD_EF01, 1, 1, "R4");
        drain("R4");

        // R3: destination byte count
        for (int c = 0; c < 4; c++) begin
            cfg_tgt = 2'(c);
            ev(0, 0, 0, 0, 1, 1, 32'h1234_5678, 1, 1, "R3");
        end
        drain("R3");

        // R6: operand before destination in the same cycle
        cfg_opnd = 2'b11; cfg_tgt = 2'b01;
        ev(1, 1, 2'b10, 32'hDEAD_BEEF, 1, 1, 32'hCAFE_F00D, 1, 1, "R6");
        drain("R6");

        // R8: configuration frozen at acceptance
        cfg_opnd = 2'b11; cfg_tgt = 2'b11;
        ev(1, 0, 2'b10, 32'h5566_7788, 1, 1, 32'h99AA_BBCC, 1, 1, "R8");
        cfg_opnd = 2'b00; cfg_tgt = 2'b00;
        drain("R8");

        // R5: random events, configuration churning while items wait
        for (int i = 0; i < 300; i++) begin
            cfg_opnd = 2'($urandom_range(0, 3));
            cfg_tgt  = 2'($urandom_range(0, 3));
            ev(1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)), $urandom,
               1'($urandom), 1'($urandom), $urandom, 1, 1, "R5");
            for (int g = 0; g < 18 + int'($urandom_range(0, 7)); g++) begin
                cfg_opnd = 2'($urandom_range(0, 3));
                cfg_tgt  = 2'($urandom_range(0, 3));
                @(negedge clk);
            end
        end
        drain("R5");
        check(trc_ovf == 1'b0, "R7", "no overflow under light load", trc_ovf, 0);

        // R7 / R10: fill the queue, one free entry at the fifth cycle
        cfg_opnd = 2'b11; cfg_tgt = 2'b11;
        first_v = -1; last_v = -1;
        for (int k = 0; k < 5; k++) begin
            ev(1, 1, 2'b10, 32'hA000_0000 | 32'(k), 1, 1, 32'hB000_0000 | 32'(k),
               1, k < 4, "R7");
        end
        ev(1, 0, 2'b10, 32'hC0C0_C0C0, 0, 0, 0, 0, 1, "R7");
        check(trc_ovf == 1'b1, "R7", "overflow flag", trc_ovf, 1);
        drain("R7");
        check(last_v - first_v + 1 == 72, "R10", "gap-free nibble cycles",
              last_v - first_v + 1, 72);
        check(trc_ovf == 1'b1, "R7", "overflow sticky", trc_ovf, 1);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(trc_ovf == 1'b0 && trc_vld == 1'b0, "R9", "reset clears",
              {trc_vld, trc_ovf}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule